// File: doc/BRIEF.md
# Packed Pairwise Min/Max Unit

This unit reduces two 64-bit packed vectors to one 64-bit packed result. Each operand is split into lanes of 8, 16 or 32 bits. Neighbouring lanes of the same operand are taken two at a time, and the larger or smaller of each pair is kept. The kept values from the first operand fill the low half of the result. The kept values from the second operand fill the high half. Within each half, lower-numbered pairs land in lower-numbered lanes.

Lane width, signed or unsigned ordering, and max or min are chosen per transfer by control inputs. A transfer that asks for a reserved lane width or for a 128-bit operation gives an all-zero result with the invalid flag raised. A parameter selects between an input register stage with a valid/ready handshake and a purely combinational path.

Top module: `pairmm_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `res_valid` is 0 and `op_ready` is 1.
- R2: With `lane_sz` = 00 (8-bit lanes), result byte k (k = 0..3) is the pick from bytes 2k and 2k+1 of `src_a`. Result byte 4+k is the pick from bytes 2k and 2k+1 of `src_b`.
- R3: With `lane_sz` = 01 (16-bit lanes), result halfword k (k = 0..1) is the pick from halfwords 2k and 2k+1 of `src_a`. Halfword 2+k is the same pick from `src_b`.
- R4: With `lane_sz` = 10 (32-bit lanes), result bits [31:0] are the pick from the two words of `src_a`, and bits [63:32] are the pick from the two words of `src_b`.
- R5: `pick_min` = 0 keeps the larger element of each pair; `pick_min` = 1 keeps the smaller.
- R6: `is_unsigned` = 0 orders elements as two's complement; `is_unsigned` = 1 orders them as unsigned.
- R7: `lane_sz` = 11 is reserved: the transfer returns `res_bad` = 1 and `res_data` = 0.
- R8: `wide_req` = 1 (128-bit operation) returns `res_bad` = 1 and `res_data` = 0, for any lane width.
- R9: With the register stage, an input accepted on a clock edge (`op_valid` and `op_ready` both 1) appears on `res_valid`/`res_data` right after that edge.
- R10: While `res_valid` = 1 and `res_take` = 0, `op_ready` is 0, a new input is not accepted, and `res_data` holds its value.
- R11: When the two elements of a pair are equal, the result lane holds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Input transfer present |
| op_ready | output | 1 | Unit can accept an input |
| src_a | input | 64 | First packed operand (feeds low half of result) |
| src_b | input | 64 | Second packed operand (feeds high half of result) |
| lane_sz | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 reserved |
| is_unsigned | input | 1 | 0 = signed ordering, 1 = unsigned ordering |
| pick_min | input | 1 | 0 = keep maximum, 1 = keep minimum |
| wide_req | input | 1 | 128-bit operation request (always invalid) |
| res_valid | output | 1 | Result present |
| res_take | input | 1 | Consumer takes the result |
| res_data | output | 64 | Packed result, zero when invalid |
| res_bad | output | 1 | Reserved control combination seen |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path and the input register stage enabled (`USE_INREG` = 1). That setting brings the one-cycle latency and the back-pressure hold into reach, along with every lane width. A reference model checks each combination of width, ordering and max/min. It uses extreme values such as 0x80..., 0x7F... and all-ones, where signed and unsigned ordering give opposite answers.

// File: rtl/pairmm_pkg.sv
package pairmm_pkg;
   localparam int unsigned VEC_W = 64;
   localparam int unsigned NUM_SIZES = 3;

   typedef enum logic [1:0] {
      LANE_8  = 2'b00,
      LANE_16 = 2'b01,
      LANE_32 = 2'b10,
      LANE_RSV = 2'b11
   } lane_sz_e;

   typedef struct packed {
      logic [VEC_W-1:0] a;
      logic [VEC_W-1:0] b;
      lane_sz_e         sz;
      logic             uns;
      logic             mn;
      logic             wide;
   } pairmm_req_t;
endpackage

// File: rtl/pairmm_pick.sv
module pairmm_pick #(
   parameter int unsigned ELEM_W = 8
) (
   input  logic [ELEM_W-1:0] lo_e,
   input  logic [ELEM_W-1:0] hi_e,
   input  logic              uns,
   input  logic              want_min,
   output logic [ELEM_W-1:0] sel_e
);
   logic [ELEM_W:0] lo_x;
   logic [ELEM_W:0] hi_x;
   logic            hi_gt;

   // Extend by one bit so one signed compare covers both orderings.
   assign lo_x  = {~uns & lo_e[ELEM_W-1], lo_e};
   assign hi_x  = {~uns & hi_e[ELEM_W-1], hi_e};
   assign hi_gt = $signed(hi_x) > $signed(lo_x);
   assign sel_e = (hi_gt ^ want_min) ? hi_e : lo_e;
endmodule

// File: rtl/pairmm_reduce.sv
module pairmm_reduce #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned ELEM_W = 8
) (
   input  logic [DATA_W-1:0] vec_a,
   input  logic [DATA_W-1:0] vec_b,
   input  logic              uns,
   input  logic              want_min,
   output logic [DATA_W-1:0] vec_r
);
   localparam int unsigned PAIRS = DATA_W / (2 * ELEM_W);

   generate
      if (DATA_W % (2 * ELEM_W) != 0) begin : g_bad_w
         $error("pairmm_reduce: DATA_W must hold a whole number of lane pairs");
      end
   endgenerate

   logic [1:0][DATA_W-1:0] srcs;
   assign srcs[0] = vec_a;
   assign srcs[1] = vec_b;

   genvar s, p;
   generate
      for (s = 0; s < 2; s++) begin : g_src
         for (p = 0; p < PAIRS; p++) begin : g_pair
            pairmm_pick #(.ELEM_W(ELEM_W)) pick_i (
               .lo_e     (srcs[s][(2*p)*ELEM_W +: ELEM_W]),
               .hi_e     (srcs[s][(2*p+1)*ELEM_W +: ELEM_W]),
               .uns      (uns),
               .want_min (want_min),
               .sel_e    (vec_r[(s*PAIRS+p)*ELEM_W +: ELEM_W])
            );
         end
      end
   endgenerate
endmodule

// File: rtl/pairmm_in_stage.sv
module pairmm_in_stage
   import pairmm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_vld,
   output logic        in_rdy,
   input  pairmm_req_t in_req,
   output logic        out_vld,
   input  logic        out_take,
   output pairmm_req_t out_req
);
   logic        vld_q;
   pairmm_req_t req_q;

   assign in_rdy  = ~vld_q | out_take;
   assign out_vld = vld_q;
   assign out_req = req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         req_q <= '0;
      end else if (in_vld && in_rdy) begin
         vld_q <= 1'b1;
         req_q <= in_req;
      end else if (out_take) begin
         vld_q <= 1'b0;
      end
   end

   assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_rdy) |=> (out_vld && out_req == $past(in_req)));

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_take) |=> (out_vld && $stable(out_req)));
endmodule

// File: rtl/pairmm_unit.sv
module pairmm_unit
   import pairmm_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter bit          USE_INREG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [1:0]        lane_sz,
   input  logic              is_unsigned,
   input  logic              pick_min,
   input  logic              wide_req,
   output logic              res_valid,
   input  logic              res_take,
   output logic [DATA_W-1:0] res_data,
   output logic              res_bad
);
   generate
      if (DATA_W != VEC_W) begin : g_bad_data_w
         $error("pairmm_unit: DATA_W must equal the 64-bit vector width");
      end
   endgenerate

   pairmm_req_t req_in;
   pairmm_req_t req_s;
   logic        vld_s;

   assign req_in = '{a: src_a, b: src_b, sz: lane_sz_e'(lane_sz),
                     uns: is_unsigned, mn: pick_min, wide: wide_req};

   generate
      if (USE_INREG) begin : g_reg
         pairmm_in_stage stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (op_valid),
            .in_rdy   (op_ready),
            .in_req   (req_in),
            .out_vld  (vld_s),
            .out_take (res_take),
            .out_req  (req_s)
         );
      end else begin : g_comb
         assign op_ready = res_take;
         assign vld_s    = op_valid;
         assign req_s    = req_in;
      end
   endgenerate

   logic [NUM_SIZES-1:0][DATA_W-1:0] by_size;

   genvar g;
   generate
      for (g = 0; g < NUM_SIZES; g++) begin : g_width
         pairmm_reduce #(.DATA_W(DATA_W), .ELEM_W(8 << g)) red_i (
            .vec_a    (req_s.a),
            .vec_b    (req_s.b),
            .uns      (req_s.uns),
            .want_min (req_s.mn),
            .vec_r    (by_size[g])
         );
      end
   endgenerate

   logic bad_c;
   assign bad_c = req_s.wide | (req_s.sz == LANE_RSV);

   always_comb begin
      res_data = '0;
      if (!bad_c) begin
         unique case (req_s.sz)
            LANE_8:  res_data = by_size[0];
            LANE_16: res_data = by_size[1];
            LANE_32: res_data = by_size[2];
            default: res_data = '0;
         endcase
      end
   end

   assign res_valid = vld_s;
   assign res_bad   = vld_s & bad_c;

   assert_bad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bad) |-> (res_data == '0));

   assert_max_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_bad && req_s.sz == LANE_32 && req_s.uns && !req_s.mn)
      |-> (res_data[31:0] >= req_s.a[31:0] && res_data[31:0] >= req_s.a[63:32]));

   assert_min_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_bad && req_s.sz == LANE_32 && req_s.uns && req_s.mn)
      |-> (res_data[63:32] <= req_s.b[31:0] && res_data[63:32] <= req_s.b[63:32]));
endmodule

// File: tb/pairmm_unit_tb.sv
`timescale 1ns/1ps
module pairmm_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [1:0]  lane_sz = '0;
   logic        is_unsigned = 1'b0;
   logic        pick_min = 1'b0;
   logic        wide_req = 1'b0;
   logic        res_valid;
   logic        res_take = 1'b1;
   logic [63:0] res_data;
   logic        res_bad;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pairmm_unit #(.DATA_W(64), .USE_INREG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .src_a(src_a), .src_b(src_b), .lane_sz(lane_sz),
      .is_unsigned(is_unsigned), .pick_min(pick_min), .wide_req(wide_req),
      .res_valid(res_valid), .res_take(res_take), .res_data(res_data),
      .res_bad(res_bad)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] sz, input bit uns,
                                         input bit mn, input bit wide);
      logic [63:0] r = '0;
      if (wide || sz == 2'b11) return '0;
      begin
         int w = 8 << sz;
         int pairs = 32 / w;
         logic [63:0] mask = (w == 64) ? '1 : ((64'h1 << w) - 64'h1);
         for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < pairs; p++) begin
               logic [63:0] src = (s == 0) ? a : b;
               logic [63:0] x = (src >> (2*p*w)) & mask;
               logic [63:0] y = (src >> ((2*p+1)*w)) & mask;
               longint xv = longint'(x);
               longint yv = longint'(y);
               logic [63:0] pick;
               if (!uns && x[w-1]) xv = xv - (longint'(1) << w);
               if (!uns && y[w-1]) yv = yv - (longint'(1) << w);
               if (mn) pick = (yv < xv) ? y : x;
               else    pick = (yv > xv) ? y : x;
               r = r | (pick << ((s*pairs + p) * w));
            end
         end
      end
      return r;
   endfunction

   // One transfer with the consumer always taking; result sampled one edge later.
   task automatic run_one(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] sz, input bit uns, input bit mn, input bit wide);
      @(negedge clk);
      src_a = a; src_b = b; lane_sz = sz; is_unsigned = uns;
      pick_min = mn; wide_req = wide; op_valid = 1'b1; res_take = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check({req, " valid"}, {63'd0, res_valid}, 64'd1);
      check({req, " data"}, res_data, model(a, b, sz, uns, mn, wide));
      check({req, " bad"}, {63'd0, res_bad}, {63'd0, (wide || sz == 2'b11)});
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", {63'd0, res_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", {63'd0, res_valid}, 64'd0);
      check("R1 ready after reset", {63'd0, op_ready}, 64'd1);
   endtask

   task automatic t_sweep();
      logic [63:0] pats [6];
      pats[0] = 64'h7F80_FF00_8000_7FFF;
      pats[1] = 64'h8000_0000_7FFF_FFFF;
      pats[2] = 64'hFFFF_FFFF_0000_0001;
      pats[3] = 64'h0123_4567_89AB_CDEF;
      pats[4] = 64'hFEDC_BA98_7654_3210;
      pats[5] = {$urandom(), $urandom()};
      for (int sz = 0; sz < 3; sz++)
         for (int u = 0; u < 2; u++)
            for (int m = 0; m < 2; m++)
               for (int p = 0; p < 6; p++) begin
                  string tag;
                  tag = (sz == 0) ? "R2 R5 R6" : (sz == 1) ? "R3 R5 R6" : "R4 R5 R6";
                  run_one(tag, pats[p], pats[(p+1) % 6], 2'(sz), u[0], m[0], 1'b0);
               end
      for (int k = 0; k < 20; k++)
         run_one("R2 R3 R4 random", {$urandom(), $urandom()}, {$urandom(), $urandom()},
                 2'(k % 3), k[0], k[1], 1'b0);
   endtask

   task automatic t_reserved();
      run_one("R7 size 11 max", 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000, 2'b11, 1'b0, 1'b0, 1'b0);
      run_one("R7 size 11 min", 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_wide();
      for (int sz = 0; sz < 4; sz++)
         run_one("R8 wide", 64'hDEAD_BEEF_0BAD_F00D, 64'h0102_0304_0506_0708, 2'(sz), 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_equal();
      run_one("R11 equal 8", 64'h5555_5555_5555_5555, 64'h8080_8080_8080_8080, 2'b00, 1'b0, 1'b1, 1'b0);
      run_one("R11 equal 32", 64'hAAAA_0000_AAAA_0000, 64'h0000_0001_0000_0001, 2'b10, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_stall();
      logic [63:0] a1 = 64'h0000_0005_FFFF_FFFB;
      logic [63:0] a2 = 64'h1111_2222_3333_4444;
      @(negedge clk);
      src_a = a1; src_b = a2; lane_sz = 2'b10; is_unsigned = 1'b0;
      pick_min = 1'b0; wide_req = 1'b0; op_valid = 1'b1; res_take = 1'b0;
      @(negedge clk);
      check("R9 valid one cycle after accept", {63'd0, res_valid}, 64'd1);
      check("R10 ready low in stall", {63'd0, op_ready}, 64'd0);
      src_a = a2; src_b = a1; pick_min = 1'b1;
      @(negedge clk);
      check("R10 data held", res_data, model(a1, a2, 2'b10, 1'b0, 1'b0, 1'b0));
      check("R10 still valid", {63'd0, res_valid}, 64'd1);
      res_take = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check("R9 second accepted", res_data, model(a2, a1, 2'b10, 1'b0, 1'b1, 1'b0));
      @(negedge clk);
      check("R9 valid drops when taken", {63'd0, res_valid}, 64'd0);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_reserved();
      t_wide();
      t_equal();
      t_stall();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule